// File: doc/BRIEF.md
# Weighted-Slot Dispatch Group Tracker

This block follows how a scheduler packs instructions into dispatch groups. Each instruction takes up a weighted number of slots in its group: one, two or four. Every cycle the scheduler shows the block one candidate. The candidate carries a slot class, a record-form flag, a branch flag, a load flag, its stall count, and a small list of predecessor tags. Each predecessor tag is marked as an ordered store or as a data-dependent counter write.

From that candidate the block answers three questions, all combinationally:
- whether another candidate should be preferred, because this one must lead a group that has already started;
- whether issuing it now would cause a store-to-load or counter-to-branch hazard inside the current group;
- how many padding no-ops would break that hazard.

The scheduler then tells the block what it did: it emitted the candidate, it emitted a no-op, or it reset. The block updates its slot count, its branch count and its table of group member tags to match.

All pins are plain control pins. There is no stream interface, so there is no back-pressure: every command is taken in the cycle it is raised. When an emit and a no-op are raised in the same cycle, the emit is acted on and the no-op is dropped.

Top module: `dispatch_group_tracker`

## Requirements
- R1: The slot weight comes from `cand_class`. Codes 0 (plain), 3 (condition-register logical), 4 (condition-register read) and 5 (special-register write) weigh 1. Code 1 (dual) weighs 2. Code 2 (quad) weighs 4. When an instruction is emitted into an empty group, `slot_count` becomes its weight.
- R2: When `cand_record` is high, an instruction that would weigh 1 weighs 2 instead.
- R3: `prefer_other` is high exactly when the candidate must lead a group and `slot_count` is nonzero. A candidate must lead a group when its weight exceeds 1 or its class is 3, 4 or 5.
- R4: Suppose a candidate that must lead is emitted while the group holds slots, and R5 does not apply. The old group and its tags are dropped, and the candidate alone forms the new group: `slot_count` equals its weight, and only its tag is a member.
- R5: Suppose an emit arrives when `slot_count` is 5, or when the candidate is a branch and the group already holds one branch. The group is cleared, `slot_count` becomes 0, and the candidate's tag is not recorded.
- R6: `nop_hazard` is high when three things hold: the candidate is a load, one of its valid predecessors marked as a store has a tag that is in the current group, and `cand_stalls` is 0.
- R7: A branch candidate with a valid predecessor marked as a counter write, whose tag is in the current group, raises `nop_hazard` under the same stall condition as R6.
- R8: `pad_count` is nonzero only when the R6/R7 match holds (the stall count is ignored here) and `slot_count` is below 6. In that case it is 1 in special no-op mode, and otherwise it is 5 minus `slot_count`.
- R9: A no-op closes the group (`slot_count` becomes 0) in special no-op mode or when `slot_count` is 6. Otherwise it adds one slot that carries no tag.
- R10: A synchronous reset clears the slot count, the branch count and every table entry.
- R11: When `inst_emit` and `nop_emit` are high in the same cycle, the emit is acted on and the no-op has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cand_tag | input | TAG_W | Tag of the candidate instruction |
| cand_class | input | 3 | Slot class code |
| cand_record | input | 1 | Candidate is a record form |
| cand_branch | input | 1 | Candidate is a branch |
| cand_load | input | 1 | Candidate is a load |
| cand_stalls | input | 4 | Stall count for this query |
| pred_valid | input | NPRED | Predecessor entry valid |
| pred_tag | input | NPRED x TAG_W | Predecessor tags |
| pred_store | input | NPRED | Predecessor is an ordered store |
| pred_ctr | input | NPRED | Predecessor writes the counter register (data dependency) |
| special_nop | input | 1 | Group-terminating no-op mode |
| inst_emit | input | 1 | Candidate emitted this cycle |
| nop_emit | input | 1 | A no-op emitted this cycle |
| prefer_other | output | 1 | Hint to pick another candidate |
| nop_hazard | output | 1 | Hazard that needs padding |
| pad_count | output | 3 | Number of padding no-ops required |
| slot_count | output | 4 | Slots used in the current group |

## Verification
The bench builds the block with its default parameters:
- TAG_W of 6, so tags up to 63 are distinct;
- two predecessor ports, so a hit can be placed on either one;
- a tag table of depth 8, enough for a group of five single slots plus a tagless no-op slot.

With these values the bench reaches a full group at 5 slots and a closed group at 6. It also reaches the must-lead restart with a stale tag that must no longer match, and a second branch clearing the group. Padding is checked at slot counts of 1, 5 and 6, in both no-op modes.

// File: rtl/dgt_pkg.sv
package dgt_pkg;
  typedef enum logic [2:0] {
    CLS_PLAIN   = 3'd0,
    CLS_DUAL    = 3'd1,
    CLS_QUAD    = 3'd2,
    CLS_CRLOGIC = 3'd3,
    CLS_CRREAD  = 3'd4,
    CLS_SPRWR   = 3'd5
  } slot_class_e;

  localparam int CNT_W       = 4;
  localparam int WGT_W       = 3;
  localparam int FULL_SLOTS  = 5;
  localparam int CLOSE_SLOTS = 6;
  localparam int STALL_W     = 4;
  localparam int PAD_W       = 3;
endpackage

// File: rtl/dgt_weigh.sv
module dgt_weigh
  import dgt_pkg::*;
(
  input  logic [2:0]       cls,
  input  logic             record_form,
  output logic [WGT_W-1:0] weight,
  output logic             must_lead
);
  slot_class_e cls_e;
  logic [WGT_W-1:0] base_w;

  assign cls_e = slot_class_e'(cls);

  always_comb begin
    case (cls_e)
      CLS_DUAL: base_w = WGT_W'(2);
      CLS_QUAD: base_w = WGT_W'(4);
      default:  base_w = WGT_W'(1);
    endcase
    weight = (record_form && base_w == WGT_W'(1)) ? WGT_W'(2) : base_w;
  end

  always_comb begin
    case (cls_e)
      CLS_CRLOGIC, CLS_CRREAD, CLS_SPRWR: must_lead = 1'b1;
      default:                            must_lead = (weight > WGT_W'(1));
    endcase
  end
endmodule

// File: rtl/dgt_tag_table.sv
module dgt_tag_table #(
  parameter int TAG_W = 6,
  parameter int DEPTH = 8,
  parameter int NPRED = 2
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        clear,
  input  logic                        push,
  input  logic                        push_real,
  input  logic [TAG_W-1:0]            push_tag,
  input  logic [NPRED-1:0]            look_valid,
  input  logic [NPRED-1:0][TAG_W-1:0] look_tag,
  output logic [NPRED-1:0]            hit
);
  localparam int PTR_W = $clog2(DEPTH + 1);

  logic [DEPTH-1:0]            ent_valid;
  logic [DEPTH-1:0][TAG_W-1:0] ent_tag;
  logic [PTR_W-1:0]            wr_ptr;

  always_ff @(posedge clk) begin
    if (rst) begin
      ent_valid <= '0;
      ent_tag   <= '0;
      wr_ptr    <= '0;
    end else if (clear) begin
      ent_valid <= '0;
      if (push) begin
        ent_valid[0] <= push_real;
        ent_tag[0]   <= push_tag;
        wr_ptr       <= PTR_W'(1);
      end else begin
        wr_ptr <= '0;
      end
    end else if (push && wr_ptr < PTR_W'(DEPTH)) begin
      ent_valid[wr_ptr] <= push_real;
      ent_tag[wr_ptr]   <= push_tag;
      wr_ptr            <= wr_ptr + PTR_W'(1);
    end
  end

  for (genvar p = 0; p < NPRED; p++) begin : g_look
    always_comb begin
      hit[p] = 1'b0;
      for (int e = 0; e < DEPTH; e++) begin
        if (look_valid[p] && ent_valid[e] && ent_tag[e] == look_tag[p])
          hit[p] = 1'b1;
      end
    end
  end

  p_ptr_bound_r10: assert property (@(posedge clk) disable iff (rst)
    wr_ptr <= PTR_W'(DEPTH));
  p_clear_drops_r4: assert property (@(posedge clk) disable iff (rst)
    clear && !push |=> ent_valid == '0);
endmodule

// File: rtl/dgt_slot_ctl.sv
module dgt_slot_ctl
  import dgt_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             inst_emit,
  input  logic             nop_emit,
  input  logic             special_nop,
  input  logic             is_branch,
  input  logic             must_lead,
  input  logic [WGT_W-1:0] weight,
  output logic [CNT_W-1:0] slot_cnt,
  output logic             tbl_clear,
  output logic             tbl_push,
  output logic             tbl_real
);
  logic [CNT_W-1:0] slot_nxt;
  logic [1:0]       br_cnt, br_nxt;
  logic [CNT_W:0]   sum_w;

  assign sum_w = {1'b0, slot_cnt} + (CNT_W+1)'(weight);

  always_comb begin
    slot_nxt  = slot_cnt;
    br_nxt    = br_cnt;
    tbl_clear = 1'b0;
    tbl_push  = 1'b0;
    tbl_real  = 1'b0;
    if (inst_emit) begin
      if (slot_cnt == CNT_W'(FULL_SLOTS) || (is_branch && br_cnt == 2'd1)) begin
        tbl_clear = 1'b1;
        slot_nxt  = '0;
        br_nxt    = '0;
      end else if (must_lead && slot_cnt != '0) begin
        tbl_clear = 1'b1;
        tbl_push  = 1'b1;
        tbl_real  = 1'b1;
        slot_nxt  = CNT_W'(weight);
        br_nxt    = {1'b0, is_branch};
      end else begin
        tbl_push = 1'b1;
        tbl_real = 1'b1;
        slot_nxt = sum_w[CNT_W] ? '1 : sum_w[CNT_W-1:0];
        if (is_branch && br_cnt != 2'd3) br_nxt = br_cnt + 2'd1;
      end
    end else if (nop_emit) begin
      if (special_nop || slot_cnt == CNT_W'(CLOSE_SLOTS)) begin
        tbl_clear = 1'b1;
        slot_nxt  = '0;
        br_nxt    = '0;
      end else begin
        tbl_push = 1'b1;
        slot_nxt = (slot_cnt == '1) ? slot_cnt : slot_cnt + CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      slot_cnt <= '0;
      br_cnt   <= '0;
    end else begin
      slot_cnt <= slot_nxt;
      br_cnt   <= br_nxt;
    end
  end

  p_full_clear_r5: assert property (@(posedge clk) disable iff (rst)
    inst_emit && slot_cnt == CNT_W'(FULL_SLOTS) |=> slot_cnt == '0);
  p_lead_restart_r4: assert property (@(posedge clk) disable iff (rst)
    inst_emit && must_lead && slot_cnt != '0 && slot_cnt != CNT_W'(FULL_SLOTS)
      && !(is_branch && br_cnt == 2'd1)
    |=> slot_cnt == CNT_W'($past(weight)));
  p_nop_close_r9: assert property (@(posedge clk) disable iff (rst)
    nop_emit && !inst_emit && special_nop |=> slot_cnt == '0);
  p_nop_fill_r9: assert property (@(posedge clk) disable iff (rst)
    nop_emit && !inst_emit && !special_nop && slot_cnt < CNT_W'(CLOSE_SLOTS)
    |=> slot_cnt == $past(slot_cnt) + CNT_W'(1));
  p_reset_clear_r10: assert property (@(posedge clk)
    rst |=> slot_cnt == '0 && br_cnt == '0);
endmodule

// File: rtl/dispatch_group_tracker.sv
module dispatch_group_tracker
  import dgt_pkg::*;
#(
  parameter int TAG_W = 6,
  parameter int NPRED = 2,
  parameter int DEPTH = 8
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [TAG_W-1:0]            cand_tag,
  input  logic [2:0]                  cand_class,
  input  logic                        cand_record,
  input  logic                        cand_branch,
  input  logic                        cand_load,
  input  logic [STALL_W-1:0]          cand_stalls,
  input  logic [NPRED-1:0]            pred_valid,
  input  logic [NPRED-1:0][TAG_W-1:0] pred_tag,
  input  logic [NPRED-1:0]            pred_store,
  input  logic [NPRED-1:0]            pred_ctr,
  input  logic                        special_nop,
  input  logic                        inst_emit,
  input  logic                        nop_emit,
  output logic                        prefer_other,
  output logic                        nop_hazard,
  output logic [PAD_W-1:0]            pad_count,
  output logic [CNT_W-1:0]            slot_count
);
  logic [WGT_W-1:0] weight;
  logic             must_lead;
  logic             tbl_clear, tbl_push, tbl_real;
  logic [NPRED-1:0] hit;
  logic             store_hit, ctr_hit, dep_match;

  dgt_weigh u_weigh (
    .cls         (cand_class),
    .record_form (cand_record),
    .weight      (weight),
    .must_lead   (must_lead)
  );

  dgt_slot_ctl u_ctl (
    .clk         (clk),
    .rst         (rst),
    .inst_emit   (inst_emit),
    .nop_emit    (nop_emit),
    .special_nop (special_nop),
    .is_branch   (cand_branch),
    .must_lead   (must_lead),
    .weight      (weight),
    .slot_cnt    (slot_count),
    .tbl_clear   (tbl_clear),
    .tbl_push    (tbl_push),
    .tbl_real    (tbl_real)
  );

  dgt_tag_table #(.TAG_W(TAG_W), .DEPTH(DEPTH), .NPRED(NPRED)) u_tbl (
    .clk        (clk),
    .rst        (rst),
    .clear      (tbl_clear),
    .push       (tbl_push),
    .push_real  (tbl_real),
    .push_tag   (cand_tag),
    .look_valid (pred_valid),
    .look_tag   (pred_tag),
    .hit        (hit)
  );

  assign store_hit = |(hit & pred_store);
  assign ctr_hit   = |(hit & pred_ctr);
  assign dep_match = (cand_load && store_hit) || (cand_branch && ctr_hit);

  assign prefer_other = must_lead && (slot_count != '0);
  assign nop_hazard   = dep_match && (cand_stalls == '0);

  always_comb begin
    if (dep_match && slot_count < CNT_W'(CLOSE_SLOTS))
      pad_count = special_nop ? PAD_W'(1)
                              : PAD_W'(CNT_W'(FULL_SLOTS) - slot_count);
    else
      pad_count = '0;
  end

  p_pad_closed_r8: assert property (@(posedge clk) disable iff (rst)
    slot_count >= CNT_W'(CLOSE_SLOTS) |-> pad_count == '0);
  p_stall_mask_r6: assert property (@(posedge clk) disable iff (rst)
    cand_stalls != '0 |-> !nop_hazard);
  p_hint_needs_slots_r3: assert property (@(posedge clk) disable iff (rst)
    prefer_other |-> slot_count != '0);
endmodule

// File: tb/sim_dispatch_group_tracker.sv
module sim_dispatch_group_tracker;
  localparam int TAG_W = 6;
  localparam int NPRED = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [TAG_W-1:0] cand_tag = '0;
  logic [2:0] cand_class = '0;
  logic cand_record = 0, cand_branch = 0, cand_load = 0;
  logic [3:0] cand_stalls = '0;
  logic [NPRED-1:0] pred_valid = '0, pred_store = '0, pred_ctr = '0;
  logic [NPRED-1:0][TAG_W-1:0] pred_tag = '0;
  logic special_nop = 0, inst_emit = 0, nop_emit = 0;
  logic prefer_other, nop_hazard;
  logic [2:0] pad_count;
  logic [3:0] slot_count;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  dispatch_group_tracker #(.TAG_W(TAG_W), .NPRED(NPRED), .DEPTH(8)) u0 (
    .clk(clk), .rst(rst), .cand_tag(cand_tag), .cand_class(cand_class),
    .cand_record(cand_record), .cand_branch(cand_branch), .cand_load(cand_load),
    .cand_stalls(cand_stalls), .pred_valid(pred_valid), .pred_tag(pred_tag),
    .pred_store(pred_store), .pred_ctr(pred_ctr), .special_nop(special_nop),
    .inst_emit(inst_emit), .nop_emit(nop_emit), .prefer_other(prefer_other),
    .nop_hazard(nop_hazard), .pad_count(pad_count), .slot_count(slot_count)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic clr_cand();
    cand_class = 0; cand_record = 0; cand_branch = 0; cand_load = 0;
    cand_stalls = 0; pred_valid = 0; pred_store = 0; pred_ctr = 0; pred_tag = '0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1;
    @(posedge clk); #1; rst = 0;
  endtask

  task automatic emit_one(int tag, int cls, bit rec, bit br);
    @(negedge clk);
    clr_cand();
    cand_tag = TAG_W'(tag); cand_class = 3'(cls); cand_record = rec; cand_branch = br;
    inst_emit = 1;
    @(posedge clk); #1;
    inst_emit = 0;
    clr_cand();
  endtask

  task automatic nop_one();
    @(negedge clk); nop_emit = 1;
    @(posedge clk); #1; nop_emit = 0;
  endtask

  // query: load or branch candidate with one predecessor on port idx
  task automatic query(bit ld, bit br, int idx, int tag, bit st, bit ctr, int stalls);
    @(negedge clk);
    clr_cand();
    cand_load = ld; cand_branch = br; cand_stalls = 4'(stalls);
    pred_valid[idx] = 1; pred_tag[idx] = TAG_W'(tag);
    pred_store[idx] = st; pred_ctr[idx] = ctr;
    #1;
  endtask

  task automatic t_reset();
    query(1, 0, 0, 0, 1, 0, 0);
    chk("R10 slot after reset", slot_count, 0);
    chk("R10 hint after reset", prefer_other, 0);
    chk("R10 hazard after reset", nop_hazard, 0);
    clr_cand();
  endtask

  task automatic t_weights();
    emit_one(1, 1, 0, 0); chk("R1 dual weight", slot_count, 2);
    do_reset(); emit_one(1, 2, 0, 0); chk("R1 quad weight", slot_count, 4);
    do_reset(); emit_one(1, 0, 0, 0); chk("R1 plain weight", slot_count, 1);
    do_reset(); emit_one(1, 0, 1, 0); chk("R2 record raises to 2", slot_count, 2);
    do_reset(); emit_one(1, 2, 1, 0); chk("R2 quad record stays 4", slot_count, 4);
    do_reset();
  endtask

  task automatic t_must_lead();
    @(negedge clk); clr_cand(); cand_class = 2; #1;
    chk("R3 quad on empty group", prefer_other, 0);
    emit_one(5, 0, 0, 0);
    @(negedge clk); cand_class = 4; #1; chk("R3 cr read leads", prefer_other, 1);
    cand_class = 0; #1; chk("R3 plain no hint", prefer_other, 0);
    cand_class = 5; #1; chk("R3 spr write leads", prefer_other, 1);
    cand_class = 1; #1; chk("R3 dual leads", prefer_other, 1);
    cand_class = 0; cand_record = 1; #1; chk("R3 record leads", prefer_other, 1);
    emit_one(6, 1, 0, 0); chk("R4 restart count", slot_count, 2);
    query(1, 0, 0, 5, 1, 0, 0); chk("R4 old tag dropped", nop_hazard, 0);
    query(1, 0, 1, 6, 1, 0, 0); chk("R4 new tag member", nop_hazard, 1);
    clr_cand(); do_reset();
  endtask

  task automatic t_full();
    for (int i = 1; i <= 5; i++) emit_one(i, 0, 0, 0);
    chk("R5 five slots", slot_count, 5);
    emit_one(7, 0, 0, 0); chk("R5 full clears", slot_count, 0);
    query(1, 0, 0, 7, 1, 0, 0); chk("R5 clearing tag not recorded", nop_hazard, 0);
    query(1, 0, 0, 3, 1, 0, 0); chk("R5 old tags gone", nop_hazard, 0);
    clr_cand(); do_reset();
    emit_one(8, 0, 0, 1); emit_one(10, 0, 0, 0);
    chk("R5 one branch allowed", slot_count, 2);
    emit_one(9, 0, 0, 1); chk("R5 second branch clears", slot_count, 0);
    do_reset();
  endtask

  task automatic t_las();
    emit_one(10, 0, 0, 0);
    query(1, 0, 0, 10, 1, 0, 0);
    chk("R6 load after store", nop_hazard, 1);
    chk("R8 plain pad 5-1", pad_count, 4);
    query(1, 0, 1, 10, 1, 0, 2);
    chk("R6 stalled no hazard", nop_hazard, 0);
    chk("R8 pad ignores stalls", pad_count, 4);
    special_nop = 1;
    query(1, 0, 1, 10, 1, 0, 0);
    chk("R8 special pad", pad_count, 1);
    chk("R6 hazard in special mode", nop_hazard, 1);
    special_nop = 0;
    query(1, 0, 0, 10, 0, 1, 0); chk("R6 unmarked pred no hazard", nop_hazard, 0);
    query(0, 0, 0, 10, 1, 0, 0); chk("R6 non-load no hazard", nop_hazard, 0);
    query(1, 0, 0, 11, 1, 0, 0); chk("R6 foreign tag no hazard", nop_hazard, 0);
    clr_cand(); do_reset();
  endtask

  task automatic t_ctr();
    emit_one(20, 5, 0, 0);
    query(0, 1, 1, 20, 0, 1, 0); chk("R7 branch after counter set", nop_hazard, 1);
    query(0, 1, 1, 20, 0, 1, 3); chk("R7 stalled no hazard", nop_hazard, 0);
    query(0, 1, 1, 20, 1, 0, 0); chk("R7 store pred on branch", nop_hazard, 0);
    clr_cand(); do_reset();
  endtask

  task automatic t_pad_nop();
    for (int i = 30; i <= 34; i++) emit_one(i, 0, 0, 0);
    query(1, 0, 0, 30, 1, 0, 0); chk("R8 pad at five", pad_count, 0);
    clr_cand();
    nop_one(); chk("R9 nop at five adds slot", slot_count, 6);
    query(1, 0, 0, 30, 1, 0, 0);
    chk("R8 pad at six", pad_count, 0);
    chk("R6 hazard still at six", nop_hazard, 1);
    clr_cand();
    nop_one(); chk("R9 nop at six closes", slot_count, 0);
    emit_one(40, 0, 0, 0); nop_one(); chk("R9 plain nop adds", slot_count, 2);
    special_nop = 1; nop_one(); chk("R9 special nop closes", slot_count, 0);
    special_nop = 0; do_reset();
  endtask

  task automatic t_prio();
    @(negedge clk); clr_cand(); special_nop = 1;
    cand_tag = 50; inst_emit = 1; nop_emit = 1;
    @(posedge clk); #1; inst_emit = 0; nop_emit = 0; special_nop = 0;
    chk("R11 emit wins over nop", slot_count, 1);
    query(1, 0, 0, 50, 1, 0, 0); chk("R11 emitted tag kept", nop_hazard, 1);
    clr_cand();
  endtask

  task automatic t_mid_reset();
    emit_one(51, 0, 0, 0); chk("R10 pre-reset count", slot_count, 2);
    do_reset(); chk("R10 mid reset count", slot_count, 0);
    query(1, 0, 0, 51, 1, 0, 0); chk("R10 table cleared", nop_hazard, 0);
    clr_cand();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1; rst = 0;
    t_reset();
    t_weights();
    t_must_lead();
    t_full();
    t_las();
    t_ctr();
    t_pad_nop();
    t_prio();
    t_mid_reset();
    done = 1;
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("  %0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule